// File: doc/BRIEF.md
# Bitplane Pixel Plotter

This block plots one pixel into a display memory that is split into separate bitplanes. Each plane keeps one bit of every pixel, and each 16-bit word of a plane holds that bit for 16 horizontally adjacent pixels. A command gives X, Y, a colour, a display mode and one base word address per plane. The block works out which word holds the pixel and which bit within that word. It then visits each plane the mode uses. For each plane it reads the word, sets or clears the one bit from the matching colour bit, and writes the word back.

The display modes use one, two or four planes. The one-plane mode is 640x400 in a 32 KB section. The two-plane mode is 640x200 in two 16 KB sections. The four-plane mode is 320x200 in four 8 KB sections. If a command's coordinates fall outside the selected resolution, or it names an unused mode code, the block makes no memory access and gives an error pulse. The memory side is one word-wide port. A request is held until the memory grants it, and read data comes back later with a valid strobe.

Top module: `bitplane_plot`

## Requirements
- R1: After reset, busy_o, err_o and mem_req_o are low and cmd_ready_o is high.
- R2: The pixel index is Y times the line width plus X. The line width is 640 for mode 0 (1 plane) and mode 1 (2 planes), and 320 for mode 2 (4 planes). The word offset is index/16. Plane k is accessed at address base_k + offset, with wrap-around modulo 2^ADDR_W. base_k sits at cmd_base_i[16k+15:16k].
- R3: The bit position p = index mod 16 selects word bit 15-p, so the leftmost pixel of a word is bit 15.
- R4: For each plane, exactly one read of the word is followed by one write of it. The write data equals the read data except in the selected bit.
- R5: In plane k the selected bit is written as colour bit k (cmd_colour_i[k]): 1 sets it and 0 clears it.
- R6: Mode 0 accesses plane 0 only. Mode 1 accesses planes 0 and 1. Mode 2 accesses planes 0 to 3. Planes are visited in ascending order, and a plane's write finishes before the next plane's read starts.
- R7: A command is accepted when cmd_valid_i and cmd_ready_o are high. cmd_ready_o is the inverse of busy_o. busy_o is high from the cycle after a valid command is accepted until the cycle after the last plane's write is granted. Commands offered while busy have no effect.
- R8: A command with x at or above the line width, y at or above the line count (400 in mode 0, 200 in modes 1 and 2), or mode 3 makes no memory access and does not raise busy_o. err_o is high for exactly the one cycle after acceptance.
- R9: While mem_req_o is high and mem_gnt_i is low, mem_addr_o, mem_we_o and mem_wdata_o stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_x_i | input | 10 | Pixel column |
| cmd_y_i | input | 9 | Pixel line |
| cmd_mode_i | input | 2 | 0: 1 plane, 1: 2 planes, 2: 4 planes, 3: invalid |
| cmd_colour_i | input | 4 | Bit k is the value for plane k |
| cmd_base_i | input | 64 | Plane base word addresses, 16 bits per plane |
| busy_o | output | 1 | Command in progress |
| err_o | output | 1 | One-cycle pulse for a rejected command |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |

## Verification
Pixels at the first and last column of a word, at the corner of each resolution, and at arbitrary interior positions separate the width selection, the word offset and the bit reversal. Memory words are prefilled with all ones, all zeros and mixed patterns. Together with colours that set some planes and clear others, this shows that only the chosen bit moves and that each plane follows its own colour bit. Coordinates exactly on each resolution edge, and the invalid mode code, must give an error with an empty access log. Stalled grants, a base near the top of the address space, and commands offered while busy exercise request stability, address wrap and command rejection.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  localparam int DATA_W = 16;
  localparam int BIT_W  = 4;

  localparam logic [1:0] MODE_ONE  = 2'd0;
  localparam logic [1:0] MODE_TWO  = 2'd1;
  localparam logic [1:0] MODE_FOUR = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } seq_state_e;

  function automatic logic [2:0] plane_count(input logic [1:0] mode);
    case (mode)
      MODE_ONE:  plane_count = 3'd1;
      MODE_TWO:  plane_count = 3'd2;
      MODE_FOUR: plane_count = 3'd4;
      default:   plane_count = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bpp_addr_calc.sv
module bpp_addr_calc
  import bpp_pkg::*;
#(
  parameter int WIDE_W      = 640,
  parameter int NARROW_W    = 320,
  parameter int HIGH_LINES  = 400,
  parameter int LOW_LINES   = 200,
  parameter int X_W         = 10,
  parameter int Y_W         = 9,
  parameter int IDX_W       = 18,
  parameter int OFF_W       = 14
) (
  input  logic [X_W-1:0]   x_i,
  input  logic [Y_W-1:0]   y_i,
  input  logic [1:0]       mode_i,
  output logic [OFF_W-1:0] offset_o,
  output logic [BIT_W-1:0] bit_pos_o,
  output logic             in_range_o
);
  logic [IDX_W-1:0] row_wide, row_narrow, idx;

  // constant multiplies fold to shift-add
  assign row_wide   = IDX_W'(y_i) * IDX_W'(WIDE_W);
  assign row_narrow = IDX_W'(y_i) * IDX_W'(NARROW_W);

  always_comb begin
    idx        = '0;
    in_range_o = 1'b0;
    case (mode_i)
      MODE_ONE: begin
        idx        = row_wide + IDX_W'(x_i);
        in_range_o = (int'(x_i) < WIDE_W) && (int'(y_i) < HIGH_LINES);
      end
      MODE_TWO: begin
        idx        = row_wide + IDX_W'(x_i);
        in_range_o = (int'(x_i) < WIDE_W) && (int'(y_i) < LOW_LINES);
      end
      MODE_FOUR: begin
        idx        = row_narrow + IDX_W'(x_i);
        in_range_o = (int'(x_i) < NARROW_W) && (int'(y_i) < LOW_LINES);
      end
      default: begin
        idx        = '0;
        in_range_o = 1'b0;
      end
    endcase
  end

  assign offset_o  = idx[IDX_W-1:BIT_W];
  assign bit_pos_o = idx[BIT_W-1:0];
endmodule

// File: rtl/bpp_bit_merge.sv
module bpp_bit_merge
  import bpp_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [BIT_W-1:0]  bit_pos_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] mask;

  // pixel 0 is the MSB
  assign mask   = DATA_W'(1) << (BIT_W'(DATA_W - 1) - bit_pos_i);
  assign word_o = set_i ? (word_i | mask) : (word_i & ~mask);
endmodule

// File: rtl/bpp_plane_seq.sv
module bpp_plane_seq
  import bpp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PLANES_MAX = 4,
  parameter int OFF_W      = 14,
  parameter int PL_W       = 2,
  parameter int CNT_W      = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [CNT_W-1:0]             plane_cnt_i,
  input  logic [OFF_W-1:0]             offset_i,
  input  logic [BIT_W-1:0]             bit_pos_i,
  input  logic [PLANES_MAX-1:0]        colour_i,
  input  logic [PLANES_MAX*ADDR_W-1:0] base_i,
  output logic                         busy_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [DATA_W-1:0]            mem_wdata_o,
  input  logic                         mem_gnt_i,
  input  logic                         mem_rvalid_i,
  input  logic [DATA_W-1:0]            mem_rdata_i
);
  seq_state_e              state_q;
  logic [PL_W-1:0]         plane_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [OFF_W-1:0]        off_q;
  logic [BIT_W-1:0]        bit_q;
  logic [PLANES_MAX-1:0]   col_q;
  logic [ADDR_W-1:0]       base_q [PLANES_MAX];
  logic [DATA_W-1:0]       rd_q;
  logic                    last_plane;

  assign last_plane = (CNT_W'(plane_q) + CNT_W'(1)) == cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      plane_q <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
      bit_q   <= '0;
      col_q   <= '0;
      rd_q    <= '0;
      for (int k = 0; k < PLANES_MAX; k++) base_q[k] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          plane_q <= '0;
          cnt_q   <= plane_cnt_i;
          off_q   <= offset_i;
          bit_q   <= bit_pos_i;
          col_q   <= colour_i;
          for (int k = 0; k < PLANES_MAX; k++) base_q[k] <= base_i[k*ADDR_W +: ADDR_W];
          state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_gnt_i) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid_i) begin
          rd_q    <= mem_rdata_i;
          state_q <= ST_WR_REQ;
        end
        ST_WR_REQ: if (mem_gnt_i) begin
          if (last_plane) state_q <= ST_IDLE;
          else begin
            plane_q <= plane_q + PL_W'(1);
            state_q <= ST_RD_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  bpp_bit_merge u_merge (
    .word_i    (rd_q),
    .bit_pos_i (bit_q),
    .set_i     (col_q[plane_q]),
    .word_o    (mem_wdata_o)
  );

  assign busy_o     = state_q != ST_IDLE;
  assign mem_req_o  = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we_o   = state_q == ST_WR_REQ;
  assign mem_addr_o = base_q[plane_q] + ADDR_W'(off_q);

  // R4: write differs from the read word in at most one bit
  p_single_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> ($countones(mem_wdata_o ^ rd_q) <= 1));

  // R9: request held stable while not granted
  p_req_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R7: busy ends only after a granted write
  p_busy_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_req_o && mem_we_o && mem_gnt_i));

  // R6: a read grant is followed by the wait for its data
  p_read_then_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_gnt_i) |=> (busy_o && !mem_req_o));
endmodule

// File: rtl/bitplane_plot.sv
module bitplane_plot
  import bpp_pkg::*;
#(
  parameter int  ADDR_W        = 16,
  parameter int  PLANES_MAX    = 4,
  parameter int  WIDE_W        = 640,
  parameter int  NARROW_W      = 320,
  parameter int  HIGH_LINES    = 400,
  parameter int  LOW_LINES     = 200,
  parameter int  SECTION_WORDS = 16384,
  localparam int X_W           = $clog2(WIDE_W),
  localparam int Y_W           = $clog2(HIGH_LINES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  output logic                         cmd_ready_o,
  input  logic [X_W-1:0]               cmd_x_i,
  input  logic [Y_W-1:0]               cmd_y_i,
  input  logic [1:0]                   cmd_mode_i,
  input  logic [PLANES_MAX-1:0]        cmd_colour_i,
  input  logic [PLANES_MAX*ADDR_W-1:0] cmd_base_i,
  output logic                         busy_o,
  output logic                         err_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [DATA_W-1:0]            mem_wdata_o,
  input  logic                         mem_gnt_i,
  input  logic                         mem_rvalid_i,
  input  logic [DATA_W-1:0]            mem_rdata_i
);
  localparam int IDX_W = $clog2(WIDE_W * HIGH_LINES);
  localparam int OFF_W = IDX_W - BIT_W;
  localparam int PL_W  = (PLANES_MAX > 1) ? $clog2(PLANES_MAX) : 1;
  localparam int CNT_W = $clog2(PLANES_MAX + 1);

  logic [OFF_W-1:0] calc_off;
  logic [BIT_W-1:0] calc_bit;
  logic             calc_ok;
  logic             accept, start, err_q;
  logic [CNT_W-1:0] cnt;
  int               sec_lim;

  bpp_addr_calc #(
    .WIDE_W     (WIDE_W),
    .NARROW_W   (NARROW_W),
    .HIGH_LINES (HIGH_LINES),
    .LOW_LINES  (LOW_LINES),
    .X_W        (X_W),
    .Y_W        (Y_W),
    .IDX_W      (IDX_W),
    .OFF_W      (OFF_W)
  ) u_calc (
    .x_i        (cmd_x_i),
    .y_i        (cmd_y_i),
    .mode_i     (cmd_mode_i),
    .offset_o   (calc_off),
    .bit_pos_o  (calc_bit),
    .in_range_o (calc_ok)
  );

  assign cnt         = CNT_W'(plane_count(cmd_mode_i));
  assign cmd_ready_o = !busy_o;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign start       = accept && calc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= accept && !calc_ok;
  end
  assign err_o = err_q;

  bpp_plane_seq #(
    .ADDR_W     (ADDR_W),
    .PLANES_MAX (PLANES_MAX),
    .OFF_W      (OFF_W),
    .PL_W       (PL_W),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .plane_cnt_i  (cnt),
    .offset_i     (calc_off),
    .bit_pos_i    (calc_bit),
    .colour_i     (cmd_colour_i),
    .base_i       (cmd_base_i),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  always_comb begin
    case (cmd_mode_i)
      MODE_ONE:  sec_lim = SECTION_WORDS;
      MODE_TWO:  sec_lim = SECTION_WORDS / 2;
      MODE_FOUR: sec_lim = SECTION_WORDS / 4;
      default:   sec_lim = 0;
    endcase
  end

  // R2: accepted offset stays inside one plane section
  p_offset_in_section_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (int'(calc_off) < sec_lim));

  // R8: rejected command leaves memory untouched and busy low
  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !mem_req_o));

  // R7: accepted valid command raises busy next cycle
  p_start_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o);
endmodule

// File: tb/bitplane_plot_bench.sv
module bitplane_plot_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [9:0]  cmd_x = '0;
  logic [8:0]  cmd_y = '0;
  logic [1:0]  cmd_mode = '0;
  logic [3:0]  cmd_col = '0;
  logic [63:0] cmd_base = '0;
  logic        cmd_ready, busy, err;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bitplane_plot u_bitplane_plot (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_ready_o  (cmd_ready),
    .cmd_x_i      (cmd_x),
    .cmd_y_i      (cmd_y),
    .cmd_mode_i   (cmd_mode),
    .cmd_colour_i (cmd_col),
    .cmd_base_i   (cmd_base),
    .busy_o       (busy),
    .err_o        (err),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_gnt_i    (mem_gnt),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata)
  );

  // memory model
  logic [15:0] mem [int];
  logic        log_we [$];
  int          log_addr [$];
  logic [15:0] log_data [$];
  int          stall_cfg = 0;
  int          stall_cnt = 0;
  int          stab_err  = 0;
  logic        rd_pend = 1'b0;
  logic        waiting = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [15:0] hold_addr = '0;
  logic        hold_we = 1'b0;
  logic [15:0] hold_data = '0;

  function automatic logic [15:0] mrd(int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    mem_gnt    = 1'b0;
    mem_rvalid = 1'b0;
    if (rd_pend) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mrd(int'(rd_addr));
      rd_pend    = 1'b0;
    end
    if (rst_n && mem_req) begin
      if (waiting && (mem_addr != hold_addr || mem_we != hold_we ||
                      (mem_we && mem_wdata != hold_data))) stab_err++;
      if (stall_cnt < stall_cfg) begin
        stall_cnt++;
        waiting   = 1'b1;
        hold_addr = mem_addr;
        hold_we   = mem_we;
        hold_data = mem_wdata;
      end else begin
        mem_gnt   = 1'b1;
        stall_cnt = 0;
        waiting   = 1'b0;
        log_we.push_back(mem_we);
        log_addr.push_back(int'(mem_addr));
        log_data.push_back(mem_wdata);
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        else begin
          rd_pend = 1'b1;
          rd_addr = mem_addr;
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL R7: watchdog expired, actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] m);
    return (m == 2'd2) ? 320 : 640;
  endfunction
  function automatic int lines_of(input logic [1:0] m);
    return (m == 2'd0) ? 400 : 200;
  endfunction
  function automatic int planes_of(input logic [1:0] m);
    case (m)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic clear_log();
    log_we.delete();
    log_addr.delete();
    log_data.delete();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // drive one command for one accepted cycle; returns at the negedge after acceptance
  task automatic issue(input int x, input int y, input logic [1:0] m,
                       input logic [3:0] c, input logic [63:0] b);
    @(negedge clk);
    cmd_x     = 10'(x);
    cmd_y     = 9'(y);
    cmd_mode  = m;
    cmd_col   = c;
    cmd_base  = b;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_plot(input int x, input int y, input logic [1:0] m,
                          input logic [3:0] c, input logic [63:0] b,
                          input logic [15:0] pre, input int stall);
    int n, idx, off, bp;
    logic [15:0] mask;
    int adr [4];
    logic [15:0] exp_w [4];
    n    = planes_of(m);
    idx  = y * width_of(m) + x;
    off  = idx / 16;
    bp   = idx % 16;
    mask = 16'h8000 >> bp;
    for (int k = 0; k < n; k++) begin
      adr[k]      = int'(16'(b[k*16 +: 16] + 16'(off)));
      mem[adr[k]] = pre ^ 16'(k * 16'h1111);
      exp_w[k]    = c[k] ? (mem[adr[k]] | mask) : (mem[adr[k]] & ~mask);
    end
    stall_cfg = stall;
    stab_err  = 0;
    clear_log();
    issue(x, y, m, c, b);
    chk(busy == 1'b1, "R7", 32'(busy), 32'h1);
    chk(cmd_ready == 1'b0, "R7", 32'(cmd_ready), 32'h0);
    chk(err == 1'b0, "R8", 32'(err), 32'h0);
    wait_idle();
    chk(log_we.size() == 2 * n, "R6", 32'(log_we.size()), 32'(2 * n));
    if (log_we.size() == 2 * n) begin
      for (int k = 0; k < n; k++) begin
        chk(log_we[2*k] == 1'b0 && log_we[2*k+1] == 1'b1, "R4",
            {log_we[2*k], log_we[2*k+1]}, 32'h1);
        chk(log_addr[2*k] == adr[k] && log_addr[2*k+1] == adr[k], "R2",
            32'(log_addr[2*k]), 32'(adr[k]));
        chk(log_data[2*k+1] == exp_w[k], "R5", 32'(log_data[2*k+1]), 32'(exp_w[k]));
        chk(mrd(adr[k]) == exp_w[k], "R3", 32'(mrd(adr[k])), 32'(exp_w[k]));
      end
    end
    chk(stab_err == 0, "R9", 32'(stab_err), 32'h0);
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R7", {busy, cmd_ready}, 32'h1);
    stall_cfg = 0;
  endtask

  task automatic run_bad(input int x, input int y, input logic [1:0] m, input string why);
    clear_log();
    issue(x, y, m, 4'hF, 64'h4000_3000_2000_1000);
    chk(err == 1'b1, "R8", 32'(err), 32'h1);
    chk(busy == 1'b0, "R8", 32'(busy), 32'h0);
    @(negedge clk);
    chk(err == 1'b0, "R8", 32'(err), 32'h0);
    repeat (3) @(negedge clk);
    chk(log_we.size() == 0, "R8", 32'(log_we.size()), 32'h0);
    if (log_we.size() != 0) $display("  (rejected case: %s)", why);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", 32'(busy), 32'h0);
    chk(err == 1'b0, "R1", 32'(err), 32'h0);
    chk(mem_req == 1'b0, "R1", 32'(mem_req), 32'h0);
    chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'h1);
  endtask

  task automatic t_single_plane();
    run_plot(0, 0, 2'd0, 4'b0001, 64'h0000_0000_0000_1000, 16'h0000, 0);   // R3 leftmost pixel -> bit 15
    run_plot(17, 3, 2'd0, 4'b0000, 64'h0000_0000_0000_1000, 16'hFFFF, 0);  // R2 offset 121, bit 14 cleared
    run_plot(639, 399, 2'd0, 4'b0001, 64'h0000_0000_0000_0100, 16'h1234, 1); // R2 last pixel, bit 0
  endtask

  task automatic t_two_planes();
    run_plot(639, 199, 2'd1, 4'b0010, 64'h0000_0000_4000_2000, 16'h5A5A, 0); // R5 clear p0, set p1
    run_plot(8, 100, 2'd1, 4'b0001, 64'h0000_0000_6000_5000, 16'hA5A5, 2);
  endtask

  task automatic t_four_planes();
    run_plot(100, 50, 2'd2, 4'b0101, 64'h7000_6000_5000_4000, 16'h0F0F, 2); // R6 ascending, R9 stalls
    run_plot(319, 199, 2'd2, 4'b1010, 64'h3000_2000_1000_0000, 16'hFFFF, 0);
    run_plot(15, 0, 2'd2, 4'b1111, 64'hFFF0_FFE0_FFD0_FFC0, 16'h0000, 1);  // R2 no-wrap near top
    run_plot(160, 10, 2'd2, 4'b0110, 64'h0000_0010_FFF0_FF00, 16'h3C3C, 0); // R2 wrap past 0xFFFF
  endtask

  task automatic t_reject();
    run_bad(640, 0, 2'd0, "x edge mode 0");
    run_bad(0, 400, 2'd0, "y edge mode 0");
    run_bad(0, 200, 2'd1, "y edge mode 1");
    run_bad(320, 5, 2'd2, "x edge mode 2");
    run_bad(5, 5, 2'd3, "mode 3");
  endtask

  task automatic t_busy_ignore();
    int exp_addr;
    clear_log();
    mem[16'h1005] = 16'h0000;
    stall_cfg = 3;
    issue(80, 0, 2'd0, 4'b0001, 64'h0000_0000_0000_1000);
    exp_addr = 16'h1005;
    // offer a second command while busy
    cmd_x = 10'd1; cmd_y = 9'd1; cmd_mode = 2'd1; cmd_col = 4'b0011;
    cmd_base = 64'h0000_0000_9000_8000;
    cmd_valid = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R7", 32'(cmd_ready), 32'h0);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(log_we.size() == 2, "R7", 32'(log_we.size()), 32'h2);
    if (log_we.size() == 2)
      chk(log_addr[1] == exp_addr, "R7", 32'(log_addr[1]), 32'(exp_addr));
    chk(mrd(exp_addr) == 16'h8000, "R7", 32'(mrd(exp_addr)), 32'h8000);
    chk(busy == 1'b0, "R7", 32'(busy), 32'h0);
    stall_cfg = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_plane();
    t_two_planes();
    t_four_planes();
    t_reject();
    t_busy_ignore();
    run_plot(3, 7, 2'd1, 4'b0011, 64'h0000_0000_2200_1100, 16'hFFFF, 0); // after rejects, set on ones
    finish_run();
  end
endmodule